// File: doc/BRIEF.md
# Distinct-Bias Oscillator Configuration Selector

This block picks one bias setting for each of three free-running noise oscillators. A table of twelve entropy scores, one for every pairing of oscillator (0..2) and bias (0..3), is loaded through a single-entry write port. On a start pulse the block walks through every assignment in which the three oscillators get three different biases. It keeps the assignment whose summed score is largest, and it raises a flag when even that best sum falls short of a pass threshold.

The result is published in three forms. The first is a packed 6-bit bias code. The second is the best total together with the three per-oscillator scores behind it. The third is four ready-made control words: one per oscillator, plus a last word that enables all three oscillators at once. Software or a sequencer then writes these words to the noise hardware. The search takes one assignment per clock, so a run lasts 24 cycles. All results stay steady until the next accepted start.

Top module: `osc_bias_selector`

## Requirements
- R1: While idle, a cycle with `wr_en` high stores `wr_score` as the score of oscillator `wr_osc` (0..2) at bias `wr_bias`. Every later search uses the stored value. All twelve scores reset to zero.
- R2: While `busy` is high, writes to the table and further `start` pulses are ignored. The running search finishes with its original result and produces exactly one `done`.
- R3: A `start` pulse seen while idle sets `busy` on the next cycle. Exactly 24 clock edges after the edge that accepted `start`, `busy` falls and `done` is high for one single cycle.
- R4: Only assignments with three different biases are considered. `best_total` equals the largest value of score(0,b0)+score(1,b1)+score(2,b2) over all 24 such assignments.
- R5: A candidate replaces the current best only when its sum is strictly larger. Assignments are visited with b0 as the outermost loop, then b1, then b2, each loop counting upward, so a tie goes to the first assignment visited.
- R6: `bias_code` holds the bias of oscillator n in bits [2n+1:2n]. Each search starts from the code 0x24 (oscillator 2 = bias 2, oscillator 1 = bias 1, oscillator 0 = bias 0) and a best sum of 0. If no assignment sums above 0, the code stays 0x24.
- R7: `cell_scores` bits [32n+31:32n] (at the default width) hold the score of oscillator n at the chosen bias. The cells start each search at 0.
- R8: At `done`, `low_entropy` is 1 exactly when `best_total` is below the pass threshold (default 150000000). The chosen configuration is still published either way.
- R9: Control word n (n = 0..2) sits at `ctl_words` bits [24n+23:24n]. Its fields are: bias in bits [1:0] = the chosen bias of oscillator n; select in bits [4:2] = 1<<n; mode in bit [5] = 1 (normal); analog-output selector in bits [7:6] = 3 (no analog output); accumulate count in bits [23:8] = 1024.
- R10: Control word 3 has select = 3'b111 and bias = 0. Its mode, analog and count fields match the other three words.
- R11: From `done` until the next accepted `start`, `bias_code`, `best_total`, `cell_scores`, `low_entropy` and `ctl_words` do not change.
- R12: After reset, `busy`, `done` and `low_entropy` are 0, `best_total` is 0 and `bias_code` is 0x24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Score table write strobe |
| wr_osc | input | 2 | Oscillator index of the write |
| wr_bias | input | 2 | Bias index of the write |
| wr_score | input | SCORE_W | Entropy score to store |
| start | input | 1 | Begin a search |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| best_total | output | SCORE_W+2 | Largest summed score found |
| cell_scores | output | 3*SCORE_W | Per-oscillator scores of the chosen assignment |
| bias_code | output | 6 | Packed chosen biases, 2 bits per oscillator |
| low_entropy | output | 1 | Best total below pass threshold |
| ctl_words | output | 4*(CNT_W+ANLG_W+6) | Four oscillator control words |

## Verification
The checker assumes that `start` is a single-cycle pulse and that no reset arrives in the middle of a search. Under these conditions the busy-cycle counter it keeps lines up with the 24-step walk. The stability property also assumes that results change only at an accepted start or while busy, so the bench raises `start` only after the previous result has been read. Stimulus that breaks the rules on purpose (writes and a second start during a search) is applied only while `busy` is high. That is the window in which the block must ignore it.

// File: rtl/bsel_pkg.sv
package bsel_pkg;

   localparam int NOSC   = 3;
   localparam int NBIAS  = 4;
   localparam int NPERM  = 24;
   localparam int BIAS_W = 2;
   localparam int IDX_W  = 5;

   typedef logic [BIAS_W-1:0] bias_t;

   // packed so that oscillator n lands at bits [2n+1:2n]
   typedef struct packed {
      bias_t b2;
      bias_t b1;
      bias_t b0;
   } perm_t;

   localparam perm_t START_CODE = '{b2: 2'd2, b1: 2'd1, b0: 2'd0};

   // Lexicographic rank -> assignment of three distinct biases
   function automatic perm_t perm_decode(input logic [IDX_W-1:0] idx);
      perm_t p;
      int    i;
      int    r;
      int    k;
      i    = int'(idx);
      p.b0 = bias_t'(i / 6);
      p.b1 = '0;
      p.b2 = '0;
      r    = i % 6;
      k    = 0;
      for (int v = 0; v < NBIAS; v++) begin
         if (v != int'(p.b0)) begin
            if (k == r / 2) p.b1 = bias_t'(v);
            k++;
         end
      end
      k = 0;
      for (int v = 0; v < NBIAS; v++) begin
         if (v != int'(p.b0) && v != int'(p.b1)) begin
            if (k == r % 2) p.b2 = bias_t'(v);
            k++;
         end
      end
      return p;
   endfunction

endpackage

// File: rtl/bsel_table.sv
module bsel_table
   import bsel_pkg::*;
#(
   parameter int SCORE_W = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [1:0]                        wr_osc,
   input  logic [BIAS_W-1:0]                 wr_bias,
   input  logic [SCORE_W-1:0]                wr_score,
   input  perm_t                             sel,
   output logic [NOSC-1:0][SCORE_W-1:0]      rd
);

   logic [NOSC-1:0][BIAS_W-1:0] sel_v;
   assign sel_v = sel;

   for (genvar g = 0; g < NOSC; g++) begin : g_row
      logic [NBIAS-1:0][SCORE_W-1:0] row;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            row <= '0;
         end else if (wr_en && wr_osc == 2'(g)) begin
            row[wr_bias] <= wr_score;
         end
      end

      assign rd[g] = row[sel_v[g]];
   end

endmodule

// File: rtl/bsel_search.sv
module bsel_search
   import bsel_pkg::*;
#(
   parameter int          SCORE_W     = 32,
   parameter int          TOT_W       = SCORE_W + 2,
   parameter logic [63:0] PASS_THRESH = 64'd150000000
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [NOSC-1:0][SCORE_W-1:0]  cand,
   output perm_t                         perm,
   output logic                          busy,
   output logic                          done,
   output logic [TOT_W-1:0]              best_total,
   output logic [NOSC-1:0][SCORE_W-1:0]  best_cells,
   output perm_t                         best_code,
   output logic                          low_entropy
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPERM - 1);

   logic [IDX_W-1:0] idx;
   logic [TOT_W-1:0] cand_total;
   logic [TOT_W-1:0] final_total;
   logic             better;
   logic             last;

   assign perm        = perm_decode(idx);
   assign cand_total  = TOT_W'(cand[0]) + TOT_W'(cand[1]) + TOT_W'(cand[2]);
   assign better      = cand_total > best_total;
   assign last        = idx == LAST_IDX;
   assign final_total = better ? cand_total : best_total;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         done        <= 1'b0;
         idx         <= '0;
         best_total  <= '0;
         best_cells  <= '0;
         best_code   <= START_CODE;
         low_entropy <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy && start) begin
            busy       <= 1'b1;
            idx        <= '0;
            best_total <= '0;
            best_cells <= '0;
            best_code  <= START_CODE;
         end else if (busy) begin
            if (better) begin
               best_total <= cand_total;
               best_cells <= cand;
               best_code  <= perm;
            end
            if (last) begin
               busy        <= 1'b0;
               done        <= 1'b1;
               low_entropy <= 64'(final_total) < PASS_THRESH;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/bsel_ctlgen.sv
module bsel_ctlgen
   import bsel_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int ANLG_W     = 2,
   parameter int ACC_CYCLES = 1024,
   parameter int NO_ANALOG  = 3
) (
   input  perm_t                                   code,
   output logic [4*(CNT_W+ANLG_W+6)-1:0]           words
);

   localparam int CTL_W = CNT_W + ANLG_W + 6;

   logic [NOSC-1:0][BIAS_W-1:0] code_v;
   assign code_v = code;

   for (genvar n = 0; n <= NOSC; n++) begin : g_word
      logic [BIAS_W-1:0] bias_f;
      logic [NOSC-1:0]   sel_f;

      if (n < NOSC) begin : g_cell
         assign bias_f = code_v[n];
         assign sel_f  = NOSC'(1 << n);
      end else begin : g_all
         assign bias_f = '0;
         assign sel_f  = '1;
      end

      assign words[n*CTL_W +: CTL_W] =
         {CNT_W'(ACC_CYCLES), ANLG_W'(NO_ANALOG), 1'b1, sel_f, bias_f};
   end

endmodule

// File: rtl/osc_bias_selector.sv
module osc_bias_selector
   import bsel_pkg::*;
#(
   parameter int          SCORE_W     = 32,
   parameter logic [63:0] PASS_THRESH = 64'd150000000,
   parameter int          CNT_W       = 16,
   parameter int          ANLG_W      = 2,
   parameter int          ACC_CYCLES  = 1024,
   parameter int          NO_ANALOG   = 3
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [1:0]                         wr_osc,
   input  logic [1:0]                         wr_bias,
   input  logic [SCORE_W-1:0]                 wr_score,
   input  logic                               start,
   output logic                               busy,
   output logic                               done,
   output logic [SCORE_W+1:0]                 best_total,
   output logic [3*SCORE_W-1:0]               cell_scores,
   output logic [5:0]                         bias_code,
   output logic                               low_entropy,
   output logic [4*(CNT_W+ANLG_W+6)-1:0]      ctl_words
);

   localparam int TOT_W = SCORE_W + 2;

   if (SCORE_W < 8 || SCORE_W > 60) begin : g_bad_width
      $error("osc_bias_selector: SCORE_W out of range 8..60");
   end
   if ((PASS_THRESH >> TOT_W) != 64'd0) begin : g_bad_thresh
      $error("osc_bias_selector: PASS_THRESH does not fit the total width");
   end
   if (ACC_CYCLES < 0 || ACC_CYCLES >= (1 << CNT_W)) begin : g_bad_count
      $error("osc_bias_selector: ACC_CYCLES does not fit CNT_W");
   end
   if (NO_ANALOG < 0 || NO_ANALOG >= (1 << ANLG_W)) begin : g_bad_analog
      $error("osc_bias_selector: NO_ANALOG does not fit ANLG_W");
   end

   perm_t                        perm;
   perm_t                        code;
   logic [NOSC-1:0][SCORE_W-1:0] cand;
   logic [NOSC-1:0][SCORE_W-1:0] cells;
   logic                         busy_i;

   bsel_table #(.SCORE_W(SCORE_W)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && !busy_i),
      .wr_osc   (wr_osc),
      .wr_bias  (wr_bias),
      .wr_score (wr_score),
      .sel      (perm),
      .rd       (cand)
   );

   bsel_search #(
      .SCORE_W     (SCORE_W),
      .TOT_W       (TOT_W),
      .PASS_THRESH (PASS_THRESH)
   ) u_search (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .cand        (cand),
      .perm        (perm),
      .busy        (busy_i),
      .done        (done),
      .best_total  (best_total),
      .best_cells  (cells),
      .best_code   (code),
      .low_entropy (low_entropy)
   );

   bsel_ctlgen #(
      .CNT_W      (CNT_W),
      .ANLG_W     (ANLG_W),
      .ACC_CYCLES (ACC_CYCLES),
      .NO_ANALOG  (NO_ANALOG)
   ) u_ctlgen (
      .code  (code),
      .words (ctl_words)
   );

   assign busy        = busy_i;
   assign bias_code   = code;
   assign cell_scores = cells;

endmodule

// File: rtl/osc_bias_selector_chk.sv
module osc_bias_selector_chk #(
   parameter int          SCORE_W     = 32,
   parameter logic [63:0] PASS_THRESH = 64'd150000000,
   parameter int          CNT_W       = 16,
   parameter int          ANLG_W      = 2
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               start,
   input logic                               busy,
   input logic                               done,
   input logic [SCORE_W+1:0]                 best_total,
   input logic [5:0]                         bias_code,
   input logic                               low_entropy,
   input logic [4*(CNT_W+ANLG_W+6)-1:0]      ctl_words
);

   localparam int CTL_W = CNT_W + ANLG_W + 6;

   logic [5:0] busy_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)              busy_cnt <= '0;
      else if (start && !busy) busy_cnt <= '0;
      else if (busy)           busy_cnt <= busy_cnt + 1'b1;
   end

   // R3
   start_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy);

   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3
   search_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_cnt == 6'd24) && !busy);

   // R4
   distinct_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bias_code[1:0] != bias_code[3:2]) && (bias_code[1:0] != bias_code[5:4])
      && (bias_code[3:2] != bias_code[5:4]));

   // R8
   low_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> low_entropy == (64'(best_total) < PASS_THRESH));

   // R11
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start |=> $stable(bias_code) && $stable(best_total)
                          && $stable(low_entropy) && $stable(ctl_words));

   for (genvar n = 0; n < 3; n++) begin : g_word_chk
      // R9
      word_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ctl_words[n*CTL_W +: 2] == bias_code[2*n +: 2])
         && $onehot0(ctl_words[n*CTL_W+2 +: 3])
         && (ctl_words[n*CTL_W+2 +: 3] == 3'(1 << n)));
   end

   // R10
   final_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_words[3*CTL_W+2 +: 3] == 3'b111) && (ctl_words[3*CTL_W +: 2] == 2'b00));

endmodule

bind osc_bias_selector osc_bias_selector_chk #(
   .SCORE_W     (SCORE_W),
   .PASS_THRESH (PASS_THRESH),
   .CNT_W       (CNT_W),
   .ANLG_W      (ANLG_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .busy        (busy),
   .done        (done),
   .best_total  (best_total),
   .bias_code   (bias_code),
   .low_entropy (low_entropy),
   .ctl_words   (ctl_words)
);

// File: tb/test_osc_bias_selector.sv
module test_osc_bias_selector;

   localparam int SW = 32;
   localparam int TW = SW + 2;
   localparam int CW = 24;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [1:0]       wr_osc = '0;
   logic [1:0]       wr_bias = '0;
   logic [SW-1:0]    wr_score = '0;
   logic             start = 1'b0;
   logic             busy;
   logic             done;
   logic [TW-1:0]    best_total;
   logic [3*SW-1:0]  cell_scores;
   logic [5:0]       bias_code;
   logic             low_entropy;
   logic [4*CW-1:0]  ctl_words;

   always #5 clk = ~clk;

   osc_bias_selector i_osc_bias_selector (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_osc(wr_osc), .wr_bias(wr_bias),
      .wr_score(wr_score), .start(start), .busy(busy), .done(done),
      .best_total(best_total), .cell_scores(cell_scores), .bias_code(bias_code),
      .low_entropy(low_entropy), .ctl_words(ctl_words)
   );

   typedef struct {
      longint     total;
      logic [5:0] code;
      longint     c0, c1, c2;
      bit         low;
      longint     st;
   } exp_t;

   exp_t   exp_q[$];
   exp_t   mon_e;
   exp_t   last_e;
   longint model[3][4];
   longint cyc = 0;
   int     n_chk = 0;
   int     n_fail = 0;
   logic [31:0] seed = 32'h1234_5678;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic logic [CW-1:0] word_exp(input int n, input logic [5:0] code);
      logic [1:0] b;
      logic [2:0] s;
      b = (n < 3) ? code[2*n +: 2] : 2'b00;
      s = (n < 3) ? 3'(1 << n) : 3'b111;
      return {16'd1024, 2'b11, 1'b1, s, b};
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2 extra done", 1, 0);
         end else begin
            mon_e = exp_q.pop_front();
            chk(64'(best_total) == mon_e.total, "R4 best_total", 64'(best_total), mon_e.total);
            chk(bias_code == mon_e.code, "R5/R6 bias_code", 64'(bias_code), 64'(mon_e.code));
            chk(64'(cell_scores[0 +: SW]) == mon_e.c0, "R7 cell0", 64'(cell_scores[0 +: SW]), mon_e.c0);
            chk(64'(cell_scores[SW +: SW]) == mon_e.c1, "R7 cell1", 64'(cell_scores[SW +: SW]), mon_e.c1);
            chk(64'(cell_scores[2*SW +: SW]) == mon_e.c2, "R7 cell2", 64'(cell_scores[2*SW +: SW]), mon_e.c2);
            chk(low_entropy == mon_e.low, "R8 low_entropy", 64'(low_entropy), 64'(mon_e.low));
            chk(cyc - mon_e.st == 24, "R3 latency", cyc - mon_e.st, 24);
            chk(!busy, "R3 busy falls", 64'(busy), 0);
            for (int n = 0; n < 3; n++)
               chk(ctl_words[n*CW +: CW] == word_exp(n, mon_e.code), "R9 ctl word",
                   64'(ctl_words[n*CW +: CW]), 64'(word_exp(n, mon_e.code)));
            chk(ctl_words[3*CW +: CW] == word_exp(3, mon_e.code), "R10 final word",
                64'(ctl_words[3*CW +: CW]), 64'(word_exp(3, mon_e.code)));
            last_e = mon_e;
         end
      end
   end

   task automatic write_score(input int o, input int b, input longint v, input bit track);
      wr_en    = 1'b1;
      wr_osc   = 2'(o);
      wr_bias  = 2'(b);
      wr_score = SW'(v);
      if (track) model[o][b] = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic exp_t compute_exp();
      exp_t e;
      e.total = 0; e.code = 6'h24; e.c0 = 0; e.c1 = 0; e.c2 = 0;
      for (int b0 = 0; b0 < 4; b0++)
         for (int b1 = 0; b1 < 4; b1++)
            for (int b2 = 0; b2 < 4; b2++) begin
               longint t;
               if (b0 == b1 || b0 == b2 || b1 == b2) continue;
               t = model[0][b0] + model[1][b1] + model[2][b2];
               if (t > e.total) begin
                  e.total = t;
                  e.code  = {2'(b2), 2'(b1), 2'(b0)};
                  e.c0 = model[0][b0]; e.c1 = model[1][b1]; e.c2 = model[2][b2];
               end
            end
      e.low = e.total < 150000000;
      return e;
   endfunction

   // driver: push expected result, start, optionally disturb while busy
   task automatic run_search(input bit extra_start, input bit busy_write);
      exp_t e;
      e = compute_exp();
      e.st = cyc + 1;
      exp_q.push_back(e);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R3 busy after start", 64'(busy), 1);
      if (extra_start) begin
         repeat (4) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      if (busy_write) begin
         repeat (3) @(negedge clk);
         write_score(0, 0, 64'h0FFF_FFFF, 1'b0);
         write_score(2, 3, 64'h0EEE_EEEE, 1'b0);
      end
      while (exp_q.size() != 0) @(negedge clk);
      repeat (5) @(negedge clk);
      chk(bias_code == last_e.code, "R11 code held", 64'(bias_code), 64'(last_e.code));
      chk(64'(best_total) == last_e.total, "R11 total held", 64'(best_total), last_e.total);
      chk(!done && !busy, "R2 no second done", 64'(done), 0);
   endtask

   task automatic fill(input longint v);
      for (int o = 0; o < 3; o++)
         for (int b = 0; b < 4; b++) write_score(o, b, v, 1'b1);
   endtask

   task automatic fill_random();
      for (int o = 0; o < 3; o++)
         for (int b = 0; b < 4; b++) begin
            seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
            write_score(o, b, 64'(seed & 32'h0FFF_FFFF), 1'b1);
         end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int o = 0; o < 3; o++)
         for (int b = 0; b < 4; b++) model[o][b] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(!busy && !done, "R12 busy/done", 64'({busy, done}), 0);
      chk(bias_code == 6'h24, "R12 bias_code", 64'(bias_code), 64'h24);
      chk(best_total == '0, "R12 best_total", 64'(best_total), 0);
      chk(!low_entropy, "R12 low_entropy", 64'(low_entropy), 0);

      // R6 all zero table keeps the default code, R8 low flag
      run_search(1'b0, 1'b0);

      // R1 R4 random tables
      for (int k = 0; k < 3; k++) begin
         fill_random();
         run_search(1'b0, 1'b0);
      end

      // R5 tie: two equal best sums, first visited wins
      fill(1);
      write_score(0, 3, 100, 1'b1);
      write_score(1, 0, 100, 1'b1);
      run_search(1'b0, 1'b0);
      chk(last_e.code == 6'h13, "R5 tie order", 64'(last_e.code), 64'h13);

      // R4 every oscillator prefers bias 3: must still differ
      fill(5);
      for (int o = 0; o < 3; o++) write_score(o, 3, 1000 + o, 1'b1);
      run_search(1'b0, 1'b0);

      // R4 best is the last permutation visited (3,2,1)
      fill(2);
      write_score(0, 3, 90000000, 1'b1);
      write_score(1, 2, 90000000, 1'b1);
      write_score(2, 1, 90000000, 1'b1);
      run_search(1'b0, 1'b0);
      chk(last_e.code == 6'h1B, "R4 last permutation", 64'(last_e.code), 64'h1B);

      // R8 threshold boundary: exactly at and one below
      fill(0);
      write_score(0, 1, 150000000, 1'b1);
      run_search(1'b0, 1'b0);
      chk(!last_e.low, "R8 at threshold", 64'(last_e.low), 0);
      write_score(0, 1, 149999999, 1'b1);
      run_search(1'b0, 1'b0);
      chk(last_e.low, "R8 below threshold", 64'(last_e.low), 1);

      // R2 writes and start while busy ignored; rerun shows table untouched
      fill_random();
      run_search(1'b1, 1'b1);
      run_search(1'b0, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule